// File: doc/BRIEF.md
# Partition Mode Entry Controller

This block keeps the requested and the reported power/clock state of four chip partitions behind a 32-bit register bus. Each partition owns a group of registers: a configuration word holding its clock-enable and output-safe-state bits, an update-flag word that picks which of those fields should move, a status word that reports the state actually reached, and a pair of per-peripheral-block words for clock enables and the matching clock status.

Writing the configuration does not change anything by itself. Software first flags the fields to update. It then writes a two-word key to the key register at address 0x000. Every partition with flagged fields then copies the configuration it held at that moment into its status after a fixed settling delay. Its update flags clear once that copy is done. Software finds the moment of completion by polling the status word. Clock gating, power switching and reset generation are not built. Only their delay is modelled.

Top module: `part_mode_ctrl`

## Requirements
- R1: After reset, partition 0 reads configuration 0x1 and status 0x1, so its clock is on and its safe state is off. Partitions 1 to 3 read configuration 0x4 and status 0x4. All update-flag, block-enable and block-status words read 0.
- R2: Partition p's group starts at 0x100 + p*0x200. Its words sit at these offsets: configuration +0x00, update flags +0x04, status +0x08, block clock status +0x10, block clock enable +0x30. Bit 0 is the clock field and bit 2 the safe-state field in the configuration, update-flag and status words. Unused bits read 0. The block enable keeps only its NUM_BLK low bits. The key register and unmapped addresses read 0.
- R3: Writing configuration or update flags without a commit leaves status and block status unchanged.
- R4: A commit occurs when the key register receives 0x5AF0 and the next write to the key register is 0xA50F. Writes to other addresses in between do not break the sequence.
- R5: Any other value written to the key register clears the pending first key. Writing 0xA50F without a preceding 0x5AF0 does not commit.
- R6: The status is unchanged for the first SETTLE_CYC rising edges after the edge that accepts the 0xA50F write. It takes its new value on the next edge.
- R7: Only flagged fields update. The status bit of an unflagged field keeps its old value.
- R8: When the clock field is flagged, block status takes the block enable word if the configured clock bit is 1, and 0 otherwise.
- R9: The update flags of a partition read 0 once its status has been updated.
- R10: Writes to the status and block status words have no effect.
- R11: Partitions with no flags set are not changed by a commit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | ADDR_W | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_we | input | 1 | Write strobe, one write per cycle |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |

## Verification
The bench builds the block with SETTLE_CYC=3 and NUM_BLK=8. With the short delay, it can check the exact edge at which status moves, one edge before and one edge after, within a few cycles. With the narrow block width, it can check that bits written above the block count are dropped on readback. All four partitions remain, so each group base and the isolation between partitions are exercised.

// File: rtl/pmc_pkg.sv
// Shared constants of the partition mode controller: key values,
// register offsets inside a partition group and field bit positions.
package pmc_pkg;
    localparam logic [31:0] KEY_FIRST  = 32'h0000_5AF0;
    localparam logic [31:0] KEY_SECOND = 32'h0000_A50F;

    localparam logic [7:0] OFS_CFG   = 8'h00;
    localparam logic [7:0] OFS_UPD   = 8'h04;
    localparam logic [7:0] OFS_STAT  = 8'h08;
    localparam logic [7:0] OFS_BSTAT = 8'h10;
    localparam logic [7:0] OFS_BEN   = 8'h30;

    localparam int BIT_CLK  = 0;
    localparam int BIT_SAFE = 2;
endpackage

// File: rtl/pmc_key_unlock.sv
// Key sequence detector.
// Raises commit for one cycle, one edge after the key register accepts
// KEY_SECOND, provided the previous key register write was KEY_FIRST.
// Assumes key_sel already decodes the key register address.
module pmc_key_unlock (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        we,
    input  logic        key_sel,
    input  logic [31:0] wdata,
    output logic        commit
);
    import pmc_pkg::*;

    logic armed;

    // Track the first key and issue the commit pulse on the second.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed  <= 1'b0;
            commit <= 1'b0;
        end else begin
            commit <= 1'b0;
            if (we && key_sel) begin
                if (armed && wdata == KEY_SECOND) begin
                    commit <= 1'b1;
                    armed  <= 1'b0;
                end else begin
                    armed <= (wdata == KEY_FIRST);
                end
            end
        end
    end
endmodule

// File: rtl/pmc_partition.sv
// One partition register group with its settling model.
// On commit, if any update flag is set and no update is in flight, the
// group snapshots its configuration. It then applies the flagged fields
// to status SETTLE_CYC+1 edges after the key write and clears those flags.
// Assumes sel decodes this group and ofs is the byte offset in it.
module pmc_partition #(
    parameter int IDX        = 0,
    parameter int NUM_BLK    = 16,
    parameter int SETTLE_CYC = 8,
    parameter int IN_W       = (NUM_BLK > 3) ? NUM_BLK : 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel,
    input  logic [7:0]         ofs,
    input  logic               we,
    input  logic [IN_W-1:0]    wdata,
    input  logic               commit,
    output logic [31:0]        rdata,
    output logic               stat_clk,
    output logic               stat_safe,
    output logic               busy,
    output logic [1:0]         upd_pend,
    output logic [NUM_BLK-1:0] blk_stat
);
    import pmc_pkg::*;

    localparam int   CNT_W    = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC + 1) : 1;
    localparam logic RST_CLK  = (IDX == 0);
    localparam logic RST_SAFE = (IDX != 0);

    logic               cfg_clk, cfg_safe;
    logic               upd_clk, upd_safe;
    logic [NUM_BLK-1:0] blk_en;
    logic               tgt_clk, tgt_safe, take_clk, take_safe;
    logic [NUM_BLK-1:0] tgt_blk;
    logic [CNT_W-1:0]   cnt;
    logic               apply;
    logic               wr_hit;

    assign wr_hit   = sel && we;
    assign apply    = busy && (cnt == '0);
    assign upd_pend = {upd_safe, upd_clk};

    // Configuration and block enable registers written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_clk  <= RST_CLK;
            cfg_safe <= RST_SAFE;
            blk_en   <= '0;
        end else if (wr_hit) begin
            if (ofs == OFS_CFG) begin
                cfg_clk  <= wdata[BIT_CLK];
                cfg_safe <= wdata[BIT_SAFE];
            end
            if (ofs == OFS_BEN) blk_en <= wdata[NUM_BLK-1:0];
        end
    end

    // Update flags: cleared when applied, a bus write takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_clk  <= 1'b0;
            upd_safe <= 1'b0;
        end else begin
            if (apply && take_clk)  upd_clk  <= 1'b0;
            if (apply && take_safe) upd_safe <= 1'b0;
            if (wr_hit && ofs == OFS_UPD) begin
                upd_clk  <= wdata[BIT_CLK];
                upd_safe <= wdata[BIT_SAFE];
            end
        end
    end

    // Commit capture and settling countdown.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            cnt       <= '0;
            tgt_clk   <= 1'b0;
            tgt_safe  <= 1'b0;
            tgt_blk   <= '0;
            take_clk  <= 1'b0;
            take_safe <= 1'b0;
        end else if (!busy) begin
            if (commit && (upd_clk || upd_safe)) begin
                busy      <= 1'b1;
                cnt       <= CNT_W'(SETTLE_CYC - 1);
                tgt_clk   <= cfg_clk;
                tgt_safe  <= cfg_safe;
                tgt_blk   <= cfg_clk ? blk_en : '0;
                take_clk  <= upd_clk;
                take_safe <= upd_safe;
            end
        end else if (cnt == '0) begin
            busy <= 1'b0;
        end else begin
            cnt <= cnt - 1'b1;
        end
    end

    // Status fields follow the snapshot for the flagged fields only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_clk  <= RST_CLK;
            stat_safe <= RST_SAFE;
            blk_stat  <= '0;
        end else if (apply) begin
            if (take_clk) begin
                stat_clk <= tgt_clk;
                blk_stat <= tgt_blk;
            end
            if (take_safe) stat_safe <= tgt_safe;
        end
    end

    // Read mux of this group, zero when not selected.
    always_comb begin
        rdata = '0;
        if (sel) begin
            unique case (ofs)
                OFS_CFG: begin
                    rdata[BIT_CLK]  = cfg_clk;
                    rdata[BIT_SAFE] = cfg_safe;
                end
                OFS_UPD: begin
                    rdata[BIT_CLK]  = upd_clk;
                    rdata[BIT_SAFE] = upd_safe;
                end
                OFS_STAT: begin
                    rdata[BIT_CLK]  = stat_clk;
                    rdata[BIT_SAFE] = stat_safe;
                end
                OFS_BSTAT: rdata[NUM_BLK-1:0] = blk_stat;
                OFS_BEN:   rdata[NUM_BLK-1:0] = blk_en;
                default:   rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/part_mode_ctrl.sv
// Partition mode entry controller top.
// Decodes the register bus into the key register at address 0 and one
// group per partition at 0x100 + p*0x200, and ORs the group read data.
// Assumes one access per cycle and NUM_BLK of 3 to 32.
module part_mode_ctrl #(
    parameter int NUM_PART   = 4,
    parameter int NUM_BLK    = 16,
    parameter int SETTLE_CYC = 8,
    parameter int ADDR_W     = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              reg_we,
    output logic [31:0]       reg_rdata
);
    localparam int IN_W = (NUM_BLK > 3) ? NUM_BLK : 3;

    logic                              commit;
    logic                              key_sel;
    logic [NUM_PART-1:0]               part_sel;
    logic [NUM_PART-1:0][31:0]         part_rdata;
    logic [NUM_PART-1:0]               part_stat_clk;
    logic [NUM_PART-1:0]               part_stat_safe;
    logic [NUM_PART-1:0]               part_busy;
    logic [NUM_PART-1:0][1:0]          part_upd;
    logic [NUM_PART-1:0][NUM_BLK-1:0]  part_blk;

    assign key_sel = (reg_addr == '0);

    pmc_key_unlock u_key (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .key_sel(key_sel),
        .wdata  (reg_wdata),
        .commit (commit)
    );

    for (genvar i = 0; i < NUM_PART; i++) begin : g_part
        assign part_sel[i] = reg_addr[8] &&
                             (reg_addr[ADDR_W-1:9] == (ADDR_W-9)'(i));

        pmc_partition #(
            .IDX       (i),
            .NUM_BLK   (NUM_BLK),
            .SETTLE_CYC(SETTLE_CYC),
            .IN_W      (IN_W)
        ) u_part (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel      (part_sel[i]),
            .ofs      (reg_addr[7:0]),
            .we       (reg_we),
            .wdata    (reg_wdata[IN_W-1:0]),
            .commit   (commit),
            .rdata    (part_rdata[i]),
            .stat_clk (part_stat_clk[i]),
            .stat_safe(part_stat_safe[i]),
            .busy     (part_busy[i]),
            .upd_pend (part_upd[i]),
            .blk_stat (part_blk[i])
        );
    end

    // Combine group read data; at most one group is selected.
    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NUM_PART; i++) reg_rdata |= part_rdata[i];
    end
endmodule

// File: rtl/pmc_checker.sv
// Property checker for part_mode_ctrl, attached by bind below.
// Observes the bus, the commit pulse and each partition's state.
module pmc_checker #(
    parameter int NUM_PART = 4,
    parameter int NUM_BLK  = 16,
    parameter int ADDR_W   = 12
) (
    input logic                             clk,
    input logic                             rst_n,
    input logic                             reg_we,
    input logic [ADDR_W-1:0]                reg_addr,
    input logic [31:0]                      reg_wdata,
    input logic                             commit,
    input logic [NUM_PART-1:0]              busy,
    input logic [NUM_PART-1:0]              stat_clk,
    input logic [NUM_PART-1:0]              stat_safe,
    input logic [NUM_PART-1:0][NUM_BLK-1:0] blk_stat
);
    import pmc_pkg::*;

    // R4: a commit pulse follows an accepted second key write.
    assert_commit_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> $past(reg_we && reg_addr == '0 && reg_wdata == KEY_SECOND));

    // R5: any other key value produces no commit.
    assert_bad_key_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == '0 && reg_wdata != KEY_SECOND) |=> !commit);

    for (genvar i = 0; i < NUM_PART; i++) begin : g_chk
        // R3: status is frozen while no update is in flight.
        assert_status_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !busy[i] |=> ($stable(stat_clk[i]) && $stable(stat_safe[i]) &&
                          $stable(blk_stat[i])));

        // R6: settling only starts right after a commit.
        assert_settle_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(busy[i]) |-> $past(commit));

        // R8: block clocks only report running with the partition clock on.
        assert_blk_needs_clk_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (|blk_stat[i]) |-> stat_clk[i]);
    end
endmodule

bind part_mode_ctrl pmc_checker #(
    .NUM_PART(NUM_PART),
    .NUM_BLK (NUM_BLK),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .commit   (commit),
    .busy     (part_busy),
    .stat_clk (part_stat_clk),
    .stat_safe(part_stat_safe),
    .blk_stat (part_blk)
);

// File: tb/part_mode_ctrl_tb.sv
// Directed bench for part_mode_ctrl: one task per scenario.
module part_mode_ctrl_tb;
    localparam int SETTLE = 3;
    localparam int NB     = 8;
    localparam int AW     = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [31:0]   reg_wdata = '0;
    logic          reg_we = 1'b0;
    logic [31:0]   reg_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    part_mode_ctrl #(.NUM_PART(4), .NUM_BLK(NB), .SETTLE_CYC(SETTLE), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata)
    );

    function automatic logic [AW-1:0] ga(int p, int ofs);
        return AW'(32'h100 + p * 32'h200 + ofs);
    endfunction

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(logic [AW-1:0] a, logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_commit();
        wr('0, 32'h5AF0);
        wr('0, 32'hA50F);
        idle(SETTLE + 2);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(ga(0, 'h00), v); chk("R1 p0 cfg", v, 32'h1);
        rd(ga(0, 'h08), v); chk("R1 p0 stat", v, 32'h1);
        for (int p = 1; p < 4; p++) begin
            rd(ga(p, 'h00), v); chk("R1 cfg", v, 32'h4);
            rd(ga(p, 'h08), v); chk("R1 stat", v, 32'h4);
        end
        for (int p = 0; p < 4; p++) begin
            rd(ga(p, 'h04), v); chk("R1 upd", v, 32'h0);
            rd(ga(p, 'h10), v); chk("R1 bstat", v, 32'h0);
            rd(ga(p, 'h30), v); chk("R1 ben", v, 32'h0);
        end
    endtask

    task automatic t_map();
        logic [31:0] v;
        wr(ga(2, 'h00), 32'hFFFF_FFFF);
        rd(ga(2, 'h00), v); chk("R2 cfg bits", v, 32'h5);
        wr(ga(1, 'h30), 32'h0000_FFFF);
        rd(ga(1, 'h30), v); chk("R2 ben width", v, 32'hFF);
        rd(ga(3, 'h30), v); chk("R2 group isolation", v, 32'h0);
        rd(AW'(12'h10C), v); chk("R2 unmapped", v, 32'h0);
        rd('0, v); chk("R2 key reads zero", v, 32'h0);
        wr(ga(2, 'h00), 32'h4);
        wr(ga(1, 'h30), 32'h0);
    endtask

    task automatic t_no_commit();
        logic [31:0] v;
        wr(ga(1, 'h00), 32'h1);
        wr(ga(1, 'h04), 32'h1);
        idle(SETTLE + 4);
        rd(ga(1, 'h08), v); chk("R3 stat without commit", v, 32'h4);
        rd(ga(1, 'h04), v); chk("R3 flags held", v, 32'h1);
    endtask

    task automatic t_bad_key();
        logic [31:0] v;
        wr('0, 32'hA50F);
        wr('0, 32'h5AF0);
        idle(SETTLE + 3);
        rd(ga(1, 'h08), v); chk("R5 wrong order", v, 32'h4);
        wr('0, 32'h1234);
        wr('0, 32'hA50F);
        idle(SETTLE + 3);
        rd(ga(1, 'h08), v); chk("R5 bad value clears first key", v, 32'h4);
        wr('0, 32'hA50F);
        idle(SETTLE + 3);
        rd(ga(1, 'h08), v); chk("R5 second key alone", v, 32'h4);
    endtask

    task automatic t_commit_timing();
        logic [31:0] v;
        wr('0, 32'h5AF0);
        wr(ga(3, 'h30), 32'h0);
        wr('0, 32'hA50F);
        idle(SETTLE);
        rd(ga(1, 'h08), v); chk("R6 unchanged at settle edge", v, 32'h4);
        idle(1);
        rd(ga(1, 'h08), v); chk("R4 R7 updated clock only", v, 32'h5);
        idle(1);
        rd(ga(1, 'h04), v); chk("R9 flags cleared", v, 32'h0);
        rd(ga(1, 'h00), v); chk("R9 cfg kept", v, 32'h1);
    endtask

    task automatic t_blocks();
        logic [31:0] v;
        wr(ga(2, 'h30), 32'hA5);
        wr(ga(2, 'h00), 32'h1);
        wr(ga(2, 'h04), 32'h5);
        do_commit();
        rd(ga(2, 'h08), v); chk("R7 both fields", v, 32'h1);
        rd(ga(2, 'h10), v); chk("R8 block status", v, 32'hA5);
        rd(ga(3, 'h08), v); chk("R11 unflagged partition", v, 32'h4);
        rd(ga(0, 'h08), v); chk("R11 partition 0", v, 32'h1);
        wr(ga(2, 'h00), 32'h0);
        wr(ga(2, 'h04), 32'h1);
        do_commit();
        rd(ga(2, 'h08), v); chk("R8 clock off stat", v, 32'h0);
        rd(ga(2, 'h10), v); chk("R8 clock off blocks", v, 32'h0);
    endtask

    task automatic t_readonly();
        logic [31:0] v;
        wr(ga(0, 'h08), 32'h0);
        rd(ga(0, 'h08), v); chk("R10 stat write ignored", v, 32'h1);
        wr(ga(0, 'h10), 32'hFF);
        rd(ga(0, 'h10), v); chk("R10 bstat write ignored", v, 32'h0);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_map();
        t_no_commit();
        t_bad_key();
        t_commit_timing();
        t_blocks();
        t_readonly();
        done = 1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
        end
    end
endmodule